// File: doc/BRIEF.md
# Dual-Issue Load-Use Stall Controller

This block is the hazard and group-steering logic at the decode stage of an in-order pipeline that issues two instructions per cycle. It holds a decode group of two slots. Slot 0 is always the older instruction and slot 1 the younger. Each cycle it decides which slots may issue into the execute stage. The datapath is fully bypassed, so the only hazard against instructions further down the pipe is a load whose result is wanted by the instruction directly behind it. The block compares both source operands of each decode slot against the destinations of the loads held in the two lanes of the execute/memory latch. The younger slot is also checked against the older slot's destination, because a value cannot be forwarded between the two members of one group.

The stalls are asymmetric. When the older instruction stalls, the younger one stalls with it. When the younger one stalls, the older one still issues. A lane that does not issue sends a bubble to execute (its valid bit is low). Two group-advance policies are available through a parameter. Rigid is the default: a fresh fetch group enters only after everything left in the current group has issued. Fluid lets an instruction that remains in the group move down to slot 0, and the older instruction of the next fetch group then fills slot 1.

The fetch side presents up to two instructions, packed from lane 0. The block reports how many of them it consumed that cycle, and the fetch unit shifts by that count.

Top module: `dic_issue_ctl`

## Requirements
- R1: After reset both decode slots are empty. Both stall outputs and both issue-valid outputs are 0, and with no fetch instruction offered the take count is 0.
- R2: The older slot stalls, and does not issue, when either execute/memory lane holds a load whose destination register is nonzero and equals either source register of the older instruction.
- R3: The younger slot stalls when either execute/memory lane holds a load whose nonzero destination equals either source of the younger instruction. The older slot still issues if it has no hazard of its own.
- R4: The younger slot stalls when it reads the older slot's destination, the older slot is valid and writes a register, and that destination is nonzero.
- R5: A stall of a valid older instruction always stalls a valid younger instruction.
- R6: A stall of the younger instruction never stops the older one. With no load in either execute/memory lane, a valid older instruction always issues.
- R7: Register 0 never creates a dependence. A producer that does not write a register, or an execute/memory entry that is not a load, never causes a stall.
- R8: A stalled or empty lane presents issue-valid 0 (a bubble). An issuing lane presents its own instruction's destination, write flag and load flag.
- R9: Rigid policy: while any valid slot stalls, the take count is 0 and unissued instructions stay in their slots. A younger instruction left behind then issues alone from slot 1, with slot 0 empty.
- R10: Fluid policy: when the younger instruction stalls and the older one issues, the younger moves to slot 0 in the next cycle. The older instruction of the offered fetch group enters slot 1 (take count 1), and the two may issue together.
- R11: The take count is the smaller of the free slots and the offered instructions. It is 2 only when both fetch lanes are valid and nonzero only when fetch lane 0 is valid. Taken instructions keep their fetch order, with fetch lane 0 going to the lower free slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fe_vld | input | 2 | Fetch lane valid, packed from lane 0 (lane 0 older) |
| fe_rs1 | input | 2x5 | First source register per fetch lane |
| fe_rs2 | input | 2x5 | Second source register per fetch lane |
| fe_rd | input | 2x5 | Destination register per fetch lane |
| fe_wr | input | 2 | Fetch lane writes a register |
| fe_ld | input | 2 | Fetch lane is a load |
| xm_ld | input | 2 | Execute/memory lane holds a load |
| xm_rd | input | 2x5 | Destination register per execute/memory lane |
| fe_take | output | 2 | Number of fetch instructions consumed this cycle |
| stall | output | 2 | Slot holds a valid instruction that does not issue (bit 0 older) |
| iss_vld | output | 2 | Lane issues into execute; 0 is a bubble |
| iss_rd | output | 2x5 | Destination of the issued instruction per lane |
| iss_wr | output | 2 | Issued instruction writes a register |
| iss_ld | output | 2 | Issued instruction is a load |

## Verification
Every cycle, the assertions check the following. A matching load forces an older stall. An older stall drags a valid younger along. A same-group dependence stalls the younger. With no load in flight, a valid older always issues. The take count never exceeds what fetch offers. They also check the slot movement that each policy requires after a younger-only stall. Only the bench scenarios can show the exact issue pattern from cycle to cycle, for example:
- The leftover younger issuing alone in rigid mode, against pairing with the next group in fluid mode.
- The destinations carried on each issue lane.
- Held instructions reappearing unchanged once a load leaves the execute/memory latch.
- Register 0 and non-writing producers being ignored.

// File: rtl/dic_pkg.sv
package dic_pkg;

    localparam int unsigned RW     = 5;
    localparam int unsigned LANES  = 2;
    localparam int unsigned TAKE_W = $clog2(LANES + 1);

    typedef logic [RW-1:0] reg_t;

    typedef struct packed {
        logic vld;
        reg_t rs1;
        reg_t rs2;
        reg_t rd;
        logic wr;
        logic ld;
    } dinst_t;

    typedef struct packed {
        logic ld;
        reg_t rd;
    } xm_t;

    typedef dinst_t [LANES-1:0] dgrp_t;
    typedef xm_t    [LANES-1:0] xgrp_t;

    typedef enum logic {
        ADV_RIGID = 1'b0,
        ADV_FLUID = 1'b1
    } adv_e;

    // Consumer reads a nonzero register r.
    function automatic logic reads_reg(input dinst_t c, input reg_t r);
        return c.vld && (r != '0) && ((c.rs1 == r) || (c.rs2 == r));
    endfunction

    // Consumer depends on a load sitting in one execute/memory lane.
    function automatic logic load_use(input dinst_t c, input xm_t x);
        return x.ld && reads_reg(c, x.rd);
    endfunction

    // Younger depends on the older member of the same group.
    function automatic logic group_dep(input dinst_t yng, input dinst_t old);
        return old.vld && old.wr && reads_reg(yng, old.rd);
    endfunction

    // Offered instructions, packed from lane 0.
    function automatic logic [TAKE_W-1:0] offered(input dgrp_t g);
        if (!g[0].vld)     return '0;
        else if (g[1].vld) return TAKE_W'(2);
        else               return TAKE_W'(1);
    endfunction

endpackage

// File: rtl/dic_lu_check.sv
module dic_lu_check
    import dic_pkg::*;
(
    input  dinst_t cand,
    input  xgrp_t  xm,
    output logic   hit
);
    logic [LANES-1:0] lane_hit;

    generate
        for (genvar j = 0; j < LANES; j++) begin : g_lane
            assign lane_hit[j] = load_use(cand, xm[j]);
        end
    endgenerate

    assign hit = |lane_hit;
endmodule

// File: rtl/dic_hazard.sv
module dic_hazard
    import dic_pkg::*;
(
    input  dinst_t           old_i,
    input  dinst_t           yng_i,
    input  xgrp_t            xm,
    output logic [LANES-1:0] stall_o,
    output logic [LANES-1:0] iss_o
);
    logic lu_old, lu_yng, pair_dep;
    logic st_old, st_yng;

    dic_lu_check u_lu_old (.cand(old_i), .xm(xm), .hit(lu_old));
    dic_lu_check u_lu_yng (.cand(yng_i), .xm(xm), .hit(lu_yng));

    always_comb begin
        pair_dep = group_dep(yng_i, old_i);
        st_old   = old_i.vld && lu_old;
        st_yng   = yng_i.vld && (lu_yng || pair_dep || st_old);
        stall_o  = {st_yng, st_old};
        iss_o    = {yng_i.vld && !st_yng, old_i.vld && !st_old};
    end
endmodule

// File: rtl/dic_group_seq.sv
module dic_group_seq
    import dic_pkg::*;
#(
    parameter adv_e ADV_MODE = ADV_RIGID
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANES-1:0]  iss_i,
    input  dgrp_t             fe_i,
    output dgrp_t             slot_o,
    output logic [TAKE_W-1:0] take_o
);
    dgrp_t             slot_q, slot_d;
    logic [TAKE_W-1:0] avail;
    logic              keep0, keep1;

    always_comb begin
        keep0 = slot_q[0].vld && !iss_i[0];
        keep1 = slot_q[1].vld && !iss_i[1];
        avail = offered(fe_i);
    end

    generate
        if (ADV_MODE == ADV_RIGID) begin : g_rigid
            always_comb begin
                slot_d        = slot_q;
                slot_d[0].vld = keep0;
                slot_d[1].vld = keep1;
                take_o        = '0;
                if (!keep0 && !keep1) begin
                    slot_d = '0;
                    take_o = avail;
                    if (avail != '0)         slot_d[0] = fe_i[0];
                    if (avail == TAKE_W'(2)) slot_d[1] = fe_i[1];
                end
            end
        end else begin : g_fluid
            always_comb begin
                slot_d = '0;
                take_o = '0;
                if (keep0 && keep1) begin
                    slot_d = slot_q;
                end else if (keep0 || keep1) begin
                    slot_d[0] = keep0 ? slot_q[0] : slot_q[1];
                    if (avail != '0) begin
                        slot_d[1] = fe_i[0];
                        take_o    = TAKE_W'(1);
                    end
                end else begin
                    take_o = avail;
                    if (avail != '0)         slot_d[0] = fe_i[0];
                    if (avail == TAKE_W'(2)) slot_d[1] = fe_i[1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_d;
    end

    assign slot_o = slot_q;
endmodule

// File: rtl/dic_issue_ctl.sv
module dic_issue_ctl
    import dic_pkg::*;
#(
    parameter adv_e ADV_MODE = ADV_RIGID
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [LANES-1:0]          fe_vld,
    input  logic [LANES-1:0][RW-1:0]  fe_rs1,
    input  logic [LANES-1:0][RW-1:0]  fe_rs2,
    input  logic [LANES-1:0][RW-1:0]  fe_rd,
    input  logic [LANES-1:0]          fe_wr,
    input  logic [LANES-1:0]          fe_ld,
    input  logic [LANES-1:0]          xm_ld,
    input  logic [LANES-1:0][RW-1:0]  xm_rd,
    output logic [TAKE_W-1:0]         fe_take,
    output logic [LANES-1:0]          stall,
    output logic [LANES-1:0]          iss_vld,
    output logic [LANES-1:0][RW-1:0]  iss_rd,
    output logic [LANES-1:0]          iss_wr,
    output logic [LANES-1:0]          iss_ld
);
    dgrp_t            fe_grp;
    xgrp_t            xm_grp;
    dgrp_t            slot_q;
    logic [LANES-1:0] iss_en;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_pack
            assign fe_grp[i] = '{vld: fe_vld[i], rs1: fe_rs1[i], rs2: fe_rs2[i],
                                 rd: fe_rd[i], wr: fe_wr[i], ld: fe_ld[i]};
            assign xm_grp[i] = '{ld: xm_ld[i], rd: xm_rd[i]};
            assign iss_vld[i] = iss_en[i];
            assign iss_rd[i]  = slot_q[i].rd;
            assign iss_wr[i]  = iss_en[i] && slot_q[i].wr;
            assign iss_ld[i]  = iss_en[i] && slot_q[i].ld;
        end
    endgenerate

    dic_hazard u_hazard (
        .old_i   (slot_q[0]),
        .yng_i   (slot_q[1]),
        .xm      (xm_grp),
        .stall_o (stall),
        .iss_o   (iss_en)
    );

    dic_group_seq #(.ADV_MODE(ADV_MODE)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .iss_i  (iss_en),
        .fe_i   (fe_grp),
        .slot_o (slot_q),
        .take_o (fe_take)
    );
endmodule

// File: rtl/dic_issue_ctl_chk.sv
module dic_issue_ctl_chk
    import dic_pkg::*;
#(
    parameter adv_e ADV_MODE = ADV_RIGID
) (
    input logic                     clk,
    input logic                     rst,
    input dinst_t                   slot0,
    input dinst_t                   slot1,
    input logic [LANES-1:0]         xm_ld,
    input logic [LANES-1:0][RW-1:0] xm_rd,
    input logic [LANES-1:0]         stall,
    input logic [LANES-1:0]         iss_vld,
    input logic [LANES-1:0]         fe_vld,
    input logic [TAKE_W-1:0]        fe_take
);
    AST_OLD_LOAD_HIT: assert property (@(posedge clk) disable iff (rst)
        (slot0.vld && xm_ld[1] && xm_rd[1] != '0 &&
         (slot0.rs1 == xm_rd[1] || slot0.rs2 == xm_rd[1])) |-> stall[0]); // R2

    AST_PAIR_DEP: assert property (@(posedge clk) disable iff (rst)
        (slot0.vld && slot1.vld && slot0.wr && slot0.rd != '0 &&
         slot1.rs1 == slot0.rd) |-> stall[1]); // R4

    AST_OLD_DRAGS_YNG: assert property (@(posedge clk) disable iff (rst)
        (slot1.vld && stall[0]) |-> stall[1]); // R5

    AST_OLD_FREE: assert property (@(posedge clk) disable iff (rst)
        (slot0.vld && xm_ld == '0) |-> iss_vld[0]); // R6

    AST_NO_LOAD_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        (xm_ld == '0) |-> !stall[0]); // R7

    AST_TAKE_TWO: assert property (@(posedge clk) disable iff (rst)
        (fe_take == TAKE_W'(2)) |-> (fe_vld == 2'b11)); // R11

    AST_TAKE_LANE0: assert property (@(posedge clk) disable iff (rst)
        (fe_take != '0) |-> fe_vld[0]); // R11

    generate
        if (ADV_MODE == ADV_RIGID) begin : g_rigid
            AST_RIGID_HOLD: assert property (@(posedge clk) disable iff (rst)
                (slot1.vld && stall[1]) |=> (slot1 == $past(slot1))); // R9

            AST_RIGID_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
                (fe_take != '0) |-> (stall == '0)); // R9
        end else begin : g_fluid
            AST_FLUID_SHIFT: assert property (@(posedge clk) disable iff (rst)
                (slot1.vld && stall[1] && !stall[0]) |=> (slot0 == $past(slot1))); // R10
        end
    endgenerate
endmodule

bind dic_issue_ctl dic_issue_ctl_chk #(.ADV_MODE(ADV_MODE)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .slot0   (slot_q[0]),
    .slot1   (slot_q[1]),
    .xm_ld   (xm_ld),
    .xm_rd   (xm_rd),
    .stall   (stall),
    .iss_vld (iss_vld),
    .fe_vld  (fe_vld),
    .fe_take (fe_take)
);

// File: tb/dic_issue_ctl_bench.sv
module dic_issue_ctl_bench;
    import dic_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [1:0]        fe_vld, fe_wr, fe_ld, xm_ld;
    logic [1:0][RW-1:0] fe_rs1, fe_rs2, fe_rd, xm_rd;

    logic [1:0]        r_take, r_stall, r_iss, r_wr, r_ld;
    logic [1:0][RW-1:0] r_rd;
    logic [1:0]        f_take, f_stall, f_iss, f_wr, f_ld;
    logic [1:0][RW-1:0] f_rd;

    int checks = 0;
    int fails  = 0;

    dic_issue_ctl #(.ADV_MODE(ADV_RIGID)) u_dic_issue_ctl (
        .clk(clk), .rst(rst), .fe_vld(fe_vld), .fe_rs1(fe_rs1), .fe_rs2(fe_rs2),
        .fe_rd(fe_rd), .fe_wr(fe_wr), .fe_ld(fe_ld), .xm_ld(xm_ld), .xm_rd(xm_rd),
        .fe_take(r_take), .stall(r_stall), .iss_vld(r_iss), .iss_rd(r_rd),
        .iss_wr(r_wr), .iss_ld(r_ld));

    dic_issue_ctl #(.ADV_MODE(ADV_FLUID)) u_dic_issue_ctl_fl (
        .clk(clk), .rst(rst), .fe_vld(fe_vld), .fe_rs1(fe_rs1), .fe_rs2(fe_rs2),
        .fe_rd(fe_rd), .fe_wr(fe_wr), .fe_ld(fe_ld), .xm_ld(xm_ld), .xm_rd(xm_rd),
        .fe_take(f_take), .stall(f_stall), .iss_vld(f_iss), .iss_rd(f_rd),
        .iss_wr(f_wr), .iss_ld(f_ld));

    function automatic dinst_t mk(input int s1, input int s2, input int d,
                                  input bit w, input bit l);
        return '{vld: 1'b1, rs1: reg_t'(s1), rs2: reg_t'(s2), rd: reg_t'(d), wr: w, ld: l};
    endfunction

    localparam dinst_t NONE = '0;

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic present(input dinst_t a, input dinst_t b);
        fe_vld = {b.vld, a.vld};
        fe_rs1 = {b.rs1, a.rs1};
        fe_rs2 = {b.rs2, a.rs2};
        fe_rd  = {b.rd, a.rd};
        fe_wr  = {b.wr, a.wr};
        fe_ld  = {b.ld, a.ld};
    endtask

    task automatic set_xm(input logic [1:0] ld, input int rd0, input int rd1);
        xm_ld = ld;
        xm_rd = {reg_t'(rd1), reg_t'(rd0)};
    endtask

    task automatic do_reset();
        rst = 1'b1;
        present(NONE, NONE);
        set_xm(2'b00, 0, 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic next_cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic fill(input dinst_t a, input dinst_t b);
        present(a, b);
        next_cycle();
        present(NONE, NONE);
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1", "rigid stall", r_stall, 0);
        chk("R1", "rigid issue", r_iss, 0);
        chk("R1", "rigid take", r_take, 0);
        chk("R1", "fluid stall", f_stall, 0);
        chk("R1", "fluid issue", f_iss, 0);
        present(mk(1, 2, 3, 1, 0), mk(4, 5, 6, 1, 0));
        #1;
        chk("R11", "rigid take two", r_take, 2);
        chk("R11", "fluid take two", f_take, 2);
    endtask

    task automatic t_old_load();
        do_reset();
        fill(mk(3, 4, 10, 1, 0), mk(5, 6, 11, 1, 1));
        set_xm(2'b10, 0, 3);
        #1;
        chk("R2", "old stall via lane1 rs1", r_stall[0], 1);
        chk("R5", "young dragged", r_stall[1], 1);
        chk("R8", "both bubbles", r_iss, 0);
        chk("R5", "fluid young dragged", f_stall, 3);
        set_xm(2'b01, 4, 0);
        #1;
        chk("R2", "old stall via lane0 rs2", r_stall, 3);
        next_cycle();
        set_xm(2'b00, 4, 0);
        #1;
        chk("R9", "held pair issues", r_iss, 3);
        chk("R9", "held old rd", r_rd[0], 10);
        chk("R9", "held young rd", r_rd[1], 11);
        chk("R8", "young load flag", r_ld[1], 1);
        chk("R8", "fluid held pair", f_iss, 3);
    endtask

    task automatic t_young_load();
        do_reset();
        fill(mk(1, 2, 12, 1, 1), mk(8, 7, 13, 1, 0));
        set_xm(2'b01, 7, 0);
        #1;
        chk("R3", "young stall lane0", r_stall, 2);
        chk("R6", "old still issues", r_iss, 1);
        chk("R8", "old rd on lane0", r_rd[0], 12);
        chk("R8", "old load flag", r_ld[0], 1);
        set_xm(2'b10, 0, 8);
        #1;
        chk("R3", "young stall lane1", r_stall, 2);
        chk("R6", "fluid old issues", f_iss, 1);
    endtask

    task automatic t_pair_and_advance();
        do_reset();
        fill(mk(1, 2, 9, 1, 0), mk(9, 3, 14, 1, 0));
        present(mk(21, 22, 15, 1, 0), mk(23, 24, 16, 1, 0));
        #1;
        chk("R4", "pair dependence stall", r_stall, 2);
        chk("R4", "old issues alone", r_iss, 1);
        chk("R9", "rigid take while held", r_take, 0);
        chk("R10", "fluid takes one", f_take, 1);
        next_cycle();
        #1;
        chk("R9", "rigid young alone", r_iss, 2);
        chk("R9", "rigid young rd", r_rd[1], 14);
        chk("R9", "rigid refills group", r_take, 2);
        chk("R10", "fluid pair issues", f_iss, 3);
        chk("R10", "fluid young moved", f_rd[0], 14);
        chk("R10", "fluid next older", f_rd[1], 15);
        next_cycle();
        present(NONE, NONE);
        #1;
        chk("R11", "rigid new group order 0", r_rd[0], 15);
        chk("R11", "rigid new group order 1", r_rd[1], 16);
        chk("R9", "rigid new group issues", r_iss, 3);
    endtask

    task automatic t_no_match();
        do_reset();
        fill(mk(1, 0, 0, 1, 0), mk(0, 5, 17, 1, 0));
        set_xm(2'b11, 0, 0);
        #1;
        chk("R7", "register 0 ignored stall", r_stall, 0);
        chk("R7", "register 0 ignored issue", r_iss, 3);
        next_cycle();
        present(NONE, NONE);
        fill(mk(1, 2, 9, 0, 0), mk(9, 9, 18, 1, 0));
        set_xm(2'b00, 1, 9);
        #1;
        chk("R7", "non-writer and non-load ignored", r_stall, 0);
        chk("R7", "fluid ignored", f_iss, 3);
        chk("R8", "non-writer wr flag", r_wr[0], 0);
    endtask

    task automatic t_single();
        do_reset();
        present(mk(2, 3, 19, 1, 0), NONE);
        #1;
        chk("R11", "single offered take", r_take, 1);
        next_cycle();
        present(NONE, NONE);
        #1;
        chk("R11", "single issues lane0", r_iss, 1);
        chk("R11", "single rd", r_rd[0], 19);
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_old_load();
        t_young_load();
        t_pair_and_advance();
        t_no_match();
        t_single();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule